// File: doc/BRIEF.md
# Switchable Power Domain Power-Up Sequencer

This block brings a switchable secondary power domain from off to on when that domain depends on an external supply. Software first arms the sequence: it sets the enable bit of the global control register and the power-on request bit of the domain control register, with the completion gate bit still clear. It then writes the go command to the transition command register. The block accepts the command only when the domain is off and these conditions hold. It then drives the domain power-enable output high, raises a pending flag that requests external power, and shows busy in the transition status register.

Software answers the external power request by writing one to the pending flag's bit in the clear register once the supply is ready. It closes the domain power switch through the short-switch register and sets the completion gate bit. The block enters the on state only when the pending flag is clear, the gate bit is set, the switch is closed and the external power-good input is high. Busy then drops and the domain status reads the on code. The on state is final until reset. A later drop of power-good or a repeated go command does not change it.

The sequencer has four states. `ST_OFF` goes to `ST_EXT_WAIT` on an accepted go. `ST_EXT_WAIT` goes to `ST_GATE_WAIT` once the pending flag is clear. `ST_GATE_WAIT` goes to `ST_ON` once the gate bit, the closed switch and power-good are all present. `ST_ON` has no exit.

Top module: `pwr_domain_seq`

Register word addresses (on `reg_addr`): 0 global control, 1 domain control, 2 domain status, 3 transition command, 4 transition status, 5 pending, 6 pending clear, 7 short switch. Reads are combinational. A write takes effect at the clock edge on which `reg_we` is high.

## Requirements
- R1: After reset every register reads 0 and `dom_pwr_en` is 0.
- R2: Global control bits 4..0 read back as written. Domain control bit 0 (request) and bit 8 (gate) read back as written. All other bits of both registers read 0.
- R3: A write to the transition command register with bit 1 set is a go command. It is accepted only in `ST_OFF` with global control bit 0 = 1, domain control bit 0 = 1 and domain control bit 8 = 0. Otherwise it is ignored: transition status reads 0, pending reads 0 and `dom_pwr_en` stays 0.
- R4: From the cycle after an accepted go, pending reads 2 (bit 1), transition status reads 2 (bit 1 busy) and `dom_pwr_en` is 1.
- R5: The pending flag is cleared only by a write to the pending clear register with bit 1 set. A write there with bit 1 clear, or any write to the pending register itself, leaves it set.
- R6: A write with bit 0 set to the short-switch register closes the switch, which reads back 1, only while busy. When the block is not busy such a write is ignored and the register reads 0.
- R7: The domain stays busy, with status not on, while any one of these is missing: pending cleared, domain control bit 8 set, switch closed, `ext_pwr_good` high.
- R8: When all R7 conditions hold, the domain enters the on state within three cycles. Domain status bits 4..0 then read 5'h03, transition status reads 0, and `dom_pwr_en` stays 1 even if `ext_pwr_good` later falls.
- R9: A go command while the domain is on is ignored: pending stays 0 and status stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ext_pwr_good | input | 1 | External supply ready |
| dom_pwr_en | output | 1 | Domain power enable |

## Verification
A state stuck in `ST_EXT_WAIT` shows as a pending flag that stays at 2 after a correct clear write, visible on the next read. Leaving `ST_GATE_WAIT` too early shows as busy dropping while one gate condition is still withheld. The bench withholds each condition on its own to expose this. A state that falls out of `ST_ON`, or an accepted go from a state other than off, shows as busy or pending coming back, or as `dom_pwr_en` dropping, within one cycle of the stimulus.

// File: rtl/pds_pkg.sv
package pds_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int GCTL_W      = 5;
    localparam int STAT_W      = 5;
    localparam int REQ_BIT     = 0;
    localparam int GATE_BIT    = 8;
    localparam int GO_BIT      = 1;
    localparam int PEND_BIT    = 1;
    localparam int BUSY_BIT    = 1;
    localparam int SW_BIT      = 0;
    localparam logic [STAT_W-1:0] ON_CODE = 5'h03;

    localparam logic [ADDR_W-1:0] A_GCTL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_DCTL  = 4'd1;
    localparam logic [ADDR_W-1:0] A_DSTAT = 4'd2;
    localparam logic [ADDR_W-1:0] A_XCMD  = 4'd3;
    localparam logic [ADDR_W-1:0] A_XSTAT = 4'd4;
    localparam logic [ADDR_W-1:0] A_PEND  = 4'd5;
    localparam logic [ADDR_W-1:0] A_PCLR  = 4'd6;
    localparam logic [ADDR_W-1:0] A_SW    = 4'd7;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_EXT_WAIT  = 2'd1,
        ST_GATE_WAIT = 2'd2,
        ST_ON        = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pds_regs.sv
module pds_regs
    import pds_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              go_ok,
    output logic              go_cmd,
    output logic [GCTL_W-1:0] gctl,
    output logic              dctl_req,
    output logic              dctl_gate,
    output logic              pend,
    output logic              sw_closed
);
    logic unused_wdata;
    assign unused_wdata = ^{wdata[DATA_W-1:GATE_BIT+1], wdata[GATE_BIT-1:GCTL_W]};

    logic wr_gctl, wr_dctl, wr_pclr, wr_sw;
    assign wr_gctl = we && (addr == A_GCTL);
    assign wr_dctl = we && (addr == A_DCTL);
    assign wr_pclr = we && (addr == A_PCLR) && wdata[PEND_BIT];
    assign wr_sw   = we && (addr == A_SW) && wdata[SW_BIT];
    assign go_cmd  = we && (addr == A_XCMD) && wdata[GO_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gctl      <= '0;
            dctl_req  <= 1'b0;
            dctl_gate <= 1'b0;
            pend      <= 1'b0;
            sw_closed <= 1'b0;
        end else begin
            if (wr_gctl) gctl <= wdata[GCTL_W-1:0];
            if (wr_dctl) begin
                dctl_req  <= wdata[REQ_BIT];
                dctl_gate <= wdata[GATE_BIT];
            end
            if (go_ok)        pend <= 1'b1;
            else if (wr_pclr) pend <= 1'b0;
            if (wr_sw && busy) sw_closed <= 1'b1;
        end
    end

    AST_SW_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_closed) |-> $past(busy)); // R6
    AST_PEND_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> $past(we && addr == A_PCLR)); // R5
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_cmd,
    input  logic              gctl_en,
    input  logic              dctl_req,
    input  logic              dctl_gate,
    input  logic              pend,
    input  logic              sw_closed,
    input  logic              ext_good,
    output logic              go_ok,
    output logic              busy,
    output logic              is_on,
    output logic              pwr_en,
    output seq_state_t        state_o
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        go_ok   = go_cmd && gctl_en && dctl_req && !dctl_gate && (state_q == ST_OFF);
        state_d = state_q;
        unique case (state_q)
            ST_OFF:       if (go_ok) state_d = ST_EXT_WAIT;
            ST_EXT_WAIT:  if (!pend) state_d = ST_GATE_WAIT;
            ST_GATE_WAIT: if (dctl_gate && sw_closed && ext_good) state_d = ST_ON;
            ST_ON:        state_d = ST_ON;
        endcase
    end

    always_comb begin
        busy    = (state_q == ST_EXT_WAIT) || (state_q == ST_GATE_WAIT);
        is_on   = (state_q == ST_ON);
        pwr_en  = (state_q != ST_OFF);
        state_o = state_q;
    end

    AST_ON_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_on) |-> $past(ext_good && dctl_gate && sw_closed && !pend)); // R7
    AST_ON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        is_on |=> is_on); // R8
    AST_EN_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        is_on |-> pwr_en); // R8
    AST_BUSY_NOT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && is_on)); // R8
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
    import pds_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_pwr_good,
    output logic              dom_pwr_en
);
    logic              go_cmd, go_ok, busy, is_on;
    logic [GCTL_W-1:0] gctl;
    logic              dctl_req, dctl_gate, pend, sw_closed;
    seq_state_t        state;

    pds_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .go_ok(go_ok), .go_cmd(go_cmd), .gctl(gctl),
        .dctl_req(dctl_req), .dctl_gate(dctl_gate), .pend(pend), .sw_closed(sw_closed)
    );

    pds_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go_cmd(go_cmd), .gctl_en(gctl[0]),
        .dctl_req(dctl_req), .dctl_gate(dctl_gate), .pend(pend), .sw_closed(sw_closed),
        .ext_good(ext_pwr_good), .go_ok(go_ok), .busy(busy), .is_on(is_on),
        .pwr_en(dom_pwr_en), .state_o(state)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_GCTL:  reg_rdata[GCTL_W-1:0] = gctl;
            A_DCTL:  begin
                reg_rdata[REQ_BIT]  = dctl_req;
                reg_rdata[GATE_BIT] = dctl_gate;
            end
            A_DSTAT: reg_rdata[STAT_W-1:0] = is_on ? ON_CODE : '0;
            A_XSTAT: reg_rdata[BUSY_BIT] = busy;
            A_PEND:  reg_rdata[PEND_BIT] = pend;
            A_SW:    reg_rdata[SW_BIT] = sw_closed;
            default: reg_rdata = '0;
        endcase
    end

    AST_PEND_IN_EXT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (state == ST_EXT_WAIT)); // R4
    AST_EN_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        go_ok |=> dom_pwr_en); // R4
endmodule

// File: tb/sim_pwr_domain_seq.sv
module sim_pwr_domain_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_pwr_good = 1'b0;
    logic        dom_pwr_en;
    int          n_total = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    pwr_domain_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_pwr_good(ext_pwr_good), .dom_pwr_en(dom_pwr_en)
    );

    localparam int NV = 7;
    localparam logic [3:0]  V_ADDR [NV] = '{4'd0, 4'd0, 4'd1, 4'd1, 4'd1, 4'd1, 4'd0};
    localparam logic [31:0] V_DATA [NV] = '{32'hFFFF_FFFF, 32'h0000_000A, 32'hFFFF_FFFF,
                                            32'h0000_0100, 32'h0000_0001, 32'h0, 32'h0};
    localparam logic [31:0] V_EXP  [NV] = '{32'h1F, 32'h0A, 32'h101, 32'h100, 32'h1, 32'h0, 32'h0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ext_pwr_good = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] v;
        do_reset();
        // R1
        rd(4'd0, v); chk("R1 gctl", v, 0);
        rd(4'd1, v); chk("R1 dctl", v, 0);
        rd(4'd2, v); chk("R1 dstat", v, 0);
        rd(4'd4, v); chk("R1 xstat", v, 0);
        rd(4'd5, v); chk("R1 pend", v, 0);
        rd(4'd7, v); chk("R1 sw", v, 0);
        chk("R1 pwr_en", {31'b0, dom_pwr_en}, 0);
        // R2 table walk
        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_DATA[i]);
            rd(V_ADDR[i], v); chk("R2 readback", v, V_EXP[i]);
        end
        // R3 missing global enable
        wr(4'd1, 32'h1); wr(4'd0, 32'h0); wr(4'd3, 32'h2); idle(1);
        rd(4'd4, v); chk("R3 no gctl busy", v, 0);
        chk("R3 no gctl en", {31'b0, dom_pwr_en}, 0);
        // R3 gate bit already set
        wr(4'd0, 32'h1); wr(4'd1, 32'h101); wr(4'd3, 32'h2); idle(1);
        rd(4'd5, v); chk("R3 gate set pend", v, 0);
        // R3 no request
        wr(4'd1, 32'h0); wr(4'd3, 32'h2); idle(1);
        rd(4'd4, v); chk("R3 no req busy", v, 0);
        // R3 go with bit1 clear
        wr(4'd1, 32'h1); wr(4'd3, 32'h1); idle(1);
        chk("R3 bad cmd en", {31'b0, dom_pwr_en}, 0);
        // R6 switch ignored when idle
        wr(4'd7, 32'h1); rd(4'd7, v); chk("R6 sw idle", v, 0);
        // R4 accepted go
        wr(4'd3, 32'h2);
        rd(4'd5, v); chk("R4 pend", v, 2);
        rd(4'd4, v); chk("R4 busy", v, 2);
        chk("R4 pwr_en", {31'b0, dom_pwr_en}, 1);
        // R5
        wr(4'd6, 32'h1); rd(4'd5, v); chk("R5 clr bit0 only", v, 2);
        wr(4'd5, 32'h0); rd(4'd5, v); chk("R5 write pend reg", v, 2);
        wr(4'd6, 32'h2); rd(4'd5, v); chk("R5 clear", v, 0);
        // R6 switch while busy
        wr(4'd7, 32'h1); rd(4'd7, v); chk("R6 sw busy", v, 1);
        // R7 power-good missing
        wr(4'd1, 32'h101); idle(3);
        rd(4'd4, v); chk("R7 no good busy", v, 2);
        rd(4'd2, v); chk("R7 no good stat", v, 0);
        // R7 gate bit missing
        wr(4'd1, 32'h1); ext_pwr_good = 1'b1; idle(3);
        rd(4'd4, v); chk("R7 no gate busy", v, 2);
        // R8 all present
        wr(4'd1, 32'h101); idle(3);
        rd(4'd2, v); chk("R8 on code", v, 32'h03);
        rd(4'd4, v); chk("R8 not busy", v, 0);
        chk("R8 pwr_en", {31'b0, dom_pwr_en}, 1);
        ext_pwr_good = 1'b0; idle(3);
        rd(4'd2, v); chk("R8 sticky", v, 32'h03);
        chk("R8 en sticky", {31'b0, dom_pwr_en}, 1);
        // R9 go while on
        wr(4'd1, 32'h1); wr(4'd3, 32'h2); idle(1);
        rd(4'd5, v); chk("R9 pend", v, 0);
        rd(4'd2, v); chk("R9 stat", v, 32'h03);
        // Run B: pending alone blocks completion (R7)
        do_reset();
        wr(4'd0, 32'h1); wr(4'd1, 32'h1); wr(4'd3, 32'h2);
        wr(4'd1, 32'h101); wr(4'd7, 32'h1); ext_pwr_good = 1'b1; idle(3);
        rd(4'd4, v); chk("R7 pend blocks", v, 2);
        rd(4'd2, v); chk("R7 pend stat", v, 0);
        wr(4'd6, 32'h2); idle(3);
        rd(4'd2, v); chk("R8 after clear", v, 32'h03);
        // R1 reset again
        do_reset();
        rd(4'd2, v); chk("R1 dstat after reset", v, 0);
        chk("R1 en after reset", {31'b0, dom_pwr_en}, 0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule